// File: doc/BRIEF.md
# Interrupt-Capable GPIO Bank

This block is one bank of general-purpose pins, at most 32, sitting behind a plain 32-bit register bus. The bus has a write strobe, a read strobe and a byte address that is always word aligned. Each pin works in one of three ways: as a plain input, as a plain output, or as an interrupt source.

An interrupt pin senses one of these conditions:
- a high level or a low level;
- a rising edge or a falling edge;
- both edges.

Edge events are latched into a pending vector. Software clears pending bits by writing ones. Level conditions are not latched: they are shown live. Every pin has an enable bit. A set-only register and a clear-by-zero register change the enables one pin at a time without a read-modify-write. A single interrupt line is the OR of all enabled, active status bits.

Pin inputs first pass through a two-flop synchronizer. They are then gated by a per-pin input enable, and only after that does sensing take place. A build parameter chooses what the input register shows for a pin that is driving: either the real pin level or zero. In the second case software reads the output data register instead.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every register reads zero, `pin_oe` is zero, `pin_out` is zero and `irq` is low.
- R2: `pin_oe[i]` is 1 exactly when direction bit i (offset 0x04, 1 = output) is 1 and mode bit i (offset 0x00, 1 = interrupt input) is 0. `pin_out` follows the output data register (offset 0x08). All three registers read back what was written.
- R3: Register bits at and above `NPINS` ignore writes and read as zero.
- R4: The input register (offset 0x0C) shows each synchronized pin level ANDed with its input-enable bit (offset 0x50). For a pin whose `pin_oe` is 1, it shows the pin level when `ALWAYS_IN` is 1, and 0 when `ALWAYS_IN` is 0.
- R5: A level-sensed interrupt pin has mode bit 1 and edge-select bit 0 (offset 0x24). For such a pin, status bit i (offset 0x10) equals the gated level XOR polarity bit i (offset 0x20, 1 = active low). It is not latched.
- R6: An edge-sensed interrupt pin has edge-select bit 1 and both-edge bit 0 (offset 0x4C). Such a pin latches its status bit on a rising edge when its polarity bit is 0, and on a falling edge when its polarity bit is 1. The bit stays set after the pin returns.
- R7: An edge-sensed pin with both-edge bit 1 latches its status bit on rising and on falling transitions.
- R8: Writing the clear register (offset 0x14) clears each latched status bit written with 1 and leaves bits written with 0 unchanged. If a new edge arrives in the same cycle as its clear, the bit stays set.
- R9: Writing the set-enable register (offset 0x1C) sets each enable bit (offset 0x18) written with 1. Writing offset 0x18 clears each enable bit written with 0 and leaves bits written with 1 unchanged.
- R10: `irq` is high exactly when the AND of the status and enable registers is nonzero.
- R11: With an input-enable bit at 0, the pin reads 0 in the input register and produces no level or edge condition.
- R12: A read strobe loads `rd_data` at that clock edge. The value then holds until the next read strobe. The clear and set-enable offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address of the word accessed |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered |
| pin_in | input | NPINS | Pin levels from the pads |
| pin_out | output | NPINS | Output data to the pads |
| pin_oe | output | NPINS | Per-pin output enable |
| irq | output | 1 | Combined interrupt |

## Verification
Two things can land in the same clock edge: a software clear of a pending bit and a fresh edge event on that same pin. The bench provokes this by toggling a pin and then timing a clear write, counting the synchronizer stages, so that the write strobe is sampled at the exact edge where the event latches. It then reads the status register and expects the bit still set, because the new event must win over the clear.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int MAX_PINS = 32;
    localparam int BUS_W    = 32;

    // byte offsets of the register words
    localparam int OFS_MODE  = 'h00;
    localparam int OFS_DIR   = 'h04;
    localparam int OFS_OUT   = 'h08;
    localparam int OFS_IN    = 'h0C;
    localparam int OFS_STAT  = 'h10;
    localparam int OFS_CLR   = 'h14;
    localparam int OFS_MASK  = 'h18;
    localparam int OFS_MSET  = 'h1C;
    localparam int OFS_POL   = 'h20;
    localparam int OFS_EDGE  = 'h24;
    localparam int OFS_BOTH  = 'h4C;
    localparam int OFS_INEN  = 'h50;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int NPINS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] inen,
    output logic [NPINS-1:0] gated
);
    typedef struct packed {
        logic [NPINS-1:0] s1;
        logic [NPINS-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gated = st_q.s2 & inen;
endmodule

// File: rtl/gpio_edge_sense.sv
module gpio_edge_sense #(
    parameter int NPINS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] lvl_in,
    input  logic [NPINS-1:0] mode,
    input  logic [NPINS-1:0] pol,
    input  logic [NPINS-1:0] edge_sel,
    input  logic [NPINS-1:0] both,
    output logic [NPINS-1:0] evt,
    output logic [NPINS-1:0] lvl_hit
);
    typedef struct packed {
        logic [NPINS-1:0] prev;
    } sense_t;

    sense_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic rise, fall, hit;
        assign rise = lvl_in[i] & ~st_q.prev[i];
        assign fall = ~lvl_in[i] & st_q.prev[i];
        assign hit  = both[i] ? (rise | fall) : (pol[i] ? fall : rise);
        assign evt[i]     = mode[i] & edge_sel[i] & hit;
        assign lvl_hit[i] = mode[i] & ~edge_sel[i] & (lvl_in[i] ^ pol[i]);
    end

    // an edge needs a change on the pin since the last cycle
    AST_EVT_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (evt & ~(lvl_in ^ $past(lvl_in))) == '0); // R6
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_irq_pkg::*;
#(
    parameter int NPINS     = 16,
    parameter bit ALWAYS_IN = 1'b1,
    parameter int ADDR_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic [NPINS-1:0]  pin_live,
    input  logic [NPINS-1:0]  evt,
    input  logic [NPINS-1:0]  lvl_hit,
    output logic [NPINS-1:0]  mode_o,
    output logic [NPINS-1:0]  dir_o,
    output logic [NPINS-1:0]  outd_o,
    output logic [NPINS-1:0]  pol_o,
    output logic [NPINS-1:0]  edge_o,
    output logic [NPINS-1:0]  both_o,
    output logic [NPINS-1:0]  inen_o,
    output logic [BUS_W-1:0]  rd_data,
    output logic              irq
);
    typedef struct packed {
        logic [NPINS-1:0] mode;
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] outd;
        logic [NPINS-1:0] pol;
        logic [NPINS-1:0] edg;
        logic [NPINS-1:0] both;
        logic [NPINS-1:0] inen;
        logic [NPINS-1:0] mask;
        logic [NPINS-1:0] lat;
        logic [BUS_W-1:0] rd;
    } regs_t;

    regs_t            st_d, st_q;
    logic [NPINS-1:0] wbits, clr_bits, status, driving, in_view;
    logic [BUS_W-1:0] rd_sel;
    logic             unused_hi;

    assign wbits     = bus_wdata[NPINS-1:0];
    assign unused_hi = ^(bus_wdata >> NPINS);

    assign driving = st_q.dir & ~st_q.mode;
    assign in_view = ALWAYS_IN ? pin_live : (pin_live & ~driving);
    assign status  = (st_q.lat & st_q.mode & st_q.edg) | lvl_hit;

    always_comb begin
        case (bus_addr)
            ADDR_W'(OFS_MODE): rd_sel = BUS_W'(st_q.mode);
            ADDR_W'(OFS_DIR):  rd_sel = BUS_W'(st_q.dir);
            ADDR_W'(OFS_OUT):  rd_sel = BUS_W'(st_q.outd);
            ADDR_W'(OFS_IN):   rd_sel = BUS_W'(in_view);
            ADDR_W'(OFS_STAT): rd_sel = BUS_W'(status);
            ADDR_W'(OFS_MASK): rd_sel = BUS_W'(st_q.mask);
            ADDR_W'(OFS_POL):  rd_sel = BUS_W'(st_q.pol);
            ADDR_W'(OFS_EDGE): rd_sel = BUS_W'(st_q.edg);
            ADDR_W'(OFS_BOTH): rd_sel = BUS_W'(st_q.both);
            ADDR_W'(OFS_INEN): rd_sel = BUS_W'(st_q.inen);
            default:           rd_sel = '0;
        endcase
    end

    always_comb begin
        st_d     = st_q;
        clr_bits = '0;
        if (bus_wr) begin
            case (bus_addr)
                ADDR_W'(OFS_MODE): st_d.mode = wbits;
                ADDR_W'(OFS_DIR):  st_d.dir  = wbits;
                ADDR_W'(OFS_OUT):  st_d.outd = wbits;
                ADDR_W'(OFS_CLR):  clr_bits  = wbits;
                ADDR_W'(OFS_MASK): st_d.mask = st_q.mask & wbits;
                ADDR_W'(OFS_MSET): st_d.mask = st_q.mask | wbits;
                ADDR_W'(OFS_POL):  st_d.pol  = wbits;
                ADDR_W'(OFS_EDGE): st_d.edg  = wbits;
                ADDR_W'(OFS_BOTH): st_d.both = wbits;
                ADDR_W'(OFS_INEN): st_d.inen = wbits;
                default: ;
            endcase
        end
        // a fresh event outranks a clear in the same cycle
        st_d.lat = (st_q.lat & ~clr_bits) | evt;
        if (bus_rd) st_d.rd = rd_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode_o  = st_q.mode;
    assign dir_o   = st_q.dir;
    assign outd_o  = st_q.outd;
    assign pol_o   = st_q.pol;
    assign edge_o  = st_q.edg;
    assign both_o  = st_q.both;
    assign inen_o  = st_q.inen;
    assign rd_data = st_q.rd;
    assign irq     = |(status & st_q.mask);

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (st_q.mask != '0)); // R10

    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_CLR))
        |=> ((st_q.lat & $past(wbits & ~evt)) == '0)); // R8

    AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((st_q.lat & $past(evt)) == $past(evt))); // R8

    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_MSET))
        |=> ((st_q.mask & $past(wbits)) == $past(wbits))); // R9

    AST_MASK_ZERO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_MASK))
        |=> ((st_q.mask & ~$past(wbits)) == '0)); // R9

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(rd_data)); // R12
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int NPINS     = 16,
    parameter bit ALWAYS_IN = 1'b1,
    parameter int ADDR_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       rd_data,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    logic [NPINS-1:0] gated, evt, lvl_hit;
    logic [NPINS-1:0] mode, dir, outd, pol, edge_sel, both, inen;

    initial begin
        AST_PIN_RANGE: assert (NPINS >= 1 && NPINS <= MAX_PINS); // R3
    end

    gpio_in_sync #(.NPINS(NPINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .inen   (inen),
        .gated  (gated)
    );

    gpio_edge_sense #(.NPINS(NPINS)) u_sense (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_in   (gated),
        .mode     (mode),
        .pol      (pol),
        .edge_sel (edge_sel),
        .both     (both),
        .evt      (evt),
        .lvl_hit  (lvl_hit)
    );

    gpio_bank_regs #(.NPINS(NPINS), .ALWAYS_IN(ALWAYS_IN), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pin_live  (gated),
        .evt       (evt),
        .lvl_hit   (lvl_hit),
        .mode_o    (mode),
        .dir_o     (dir),
        .outd_o    (outd),
        .pol_o     (pol),
        .edge_o    (edge_sel),
        .both_o    (both),
        .inen_o    (inen),
        .rd_data   (rd_data),
        .irq       (irq)
    );

    assign pin_out = outd;
    assign pin_oe  = dir & ~mode;

    AST_OE_OFF_FOR_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & mode) == '0); // R2
endmodule

// File: tb/sim_gpio_irq_bank.sv
`timescale 1ns/1ps
module sim_gpio_irq_bank;
    localparam int NP = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   rd_data, rd_data_b;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe, pin_out_b, pin_oe_b;
    logic          irq, irq_b;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    gpio_irq_bank #(.NPINS(NP), .ALWAYS_IN(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

    gpio_irq_bank #(.NPINS(NP), .ALWAYS_IN(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data_b),
        .pin_in(pin_in), .pin_out(pin_out_b), .pin_oe(pin_oe_b), .irq(irq_b));

    typedef struct {
        logic [31:0] exp0;
        logic [31:0] exp1;
        bit          use1;
        string       tag;
    } item_t;

    item_t sb[$];
    logic  rd_seen = 1'b0;

    always @(posedge clk) rd_seen <= bus_rd;

    // monitor: compares registered read data one half cycle after the strobe edge
    always @(negedge clk) begin
        if (rd_seen) begin
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL scoreboard: read without expected item");
            end else begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (rd_data !== it.exp0) begin
                    fails++;
                    $display("FAIL %s: actual %h expected %h", it.tag, rd_data, it.exp0);
                end
                if (it.use1) begin
                    checks++;
                    if (rd_data_b !== it.exp1) begin
                        fails++;
                        $display("FAIL %s (no-loopback build): actual %h expected %h",
                                 it.tag, rd_data_b, it.exp1);
                    end
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd2(input logic [7:0] a, input logic [31:0] e0,
                       input bit u1chk, input logic [31:0] e1, input string tag);
        item_t it;
        @(negedge clk);
        it.exp0 = e0; it.exp1 = e1; it.use1 = u1chk; it.tag = tag;
        sb.push_back(it);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        rd2(a, e, 1'b0, '0, tag);
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] e, input string tag);
        checks++;
        if (act !== e) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, e);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(32'(pin_oe), 0, "R1 pin_oe");
        chk(32'(pin_out), 0, "R1 pin_out");
        chk(32'(irq), 0, "R1 irq");
        rd(8'h00, 0, "R1 mode");
        rd(8'h18, 0, "R1 mask");
        rd(8'h10, 0, "R1 status");
        rd(8'h50, 0, "R1 inen");

        // R3 upper bits, R2 direction/output
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, 32'h0000_FFFF, "R3 dir upper bits");
        wr(8'h08, 32'h5A5A_A5A5);
        rd(8'h08, 32'h0000_A5A5, "R3 out upper bits");
        @(negedge clk);
        chk(32'(pin_out), 32'h0000_A5A5, "R2 pin_out");
        chk(32'(pin_oe), 32'h0000_FFFF, "R2 pin_oe all out");
        wr(8'h00, 32'h0000_000F);
        @(negedge clk);
        chk(32'(pin_oe), 32'h0000_FFF0, "R2 pin_oe irq pins off");

        // R4 input view, R11 input enable
        wr(8'h50, 32'h0000_FFFF);
        pin_in = 16'h00F3;
        settle();
        rd2(8'h0C, 32'h0000_00F3, 1'b1, 32'h0000_0003, "R4 input view");
        wr(8'h50, 32'h0000_0000);
        settle();
        rd2(8'h0C, 0, 1'b1, 0, "R11 input gated off");
        rd(8'h10, 0, "R11 no level hit when gated");
        pin_in = 16'h0000;
        wr(8'h50, 32'h0000_FFFF);
        settle();

        // R5 level sensing
        wr(8'h20, 32'h0000_0002);
        settle();
        rd(8'h10, 32'h0000_0002, "R5 active-low level");
        pin_in = 16'h0001;
        settle();
        rd(8'h10, 32'h0000_0003, "R5 active-high level");
        pin_in = 16'h0000;
        settle();
        rd(8'h10, 32'h0000_0002, "R5 level not latched");

        // R9 / R10 enables and interrupt
        chk(32'(irq), 0, "R10 irq masked");
        wr(8'h1C, 32'h0000_0002);
        rd(8'h18, 32'h0000_0002, "R9 set-enable");
        @(negedge clk);
        chk(32'(irq), 1, "R10 irq on enabled level");
        wr(8'h18, 32'hFFFF_FFFD);
        rd(8'h18, 0, "R9 write-zero clears");
        @(negedge clk);
        chk(32'(irq), 0, "R10 irq after mask");
        wr(8'h1C, 32'h0000_000F);
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h18, 32'h0000_000F, "R9 write-one keeps");
        rd(8'h1C, 0, "R12 set-enable reads zero");
        wr(8'h20, 32'h0000_0000);
        settle();
        chk(32'(irq), 0, "R10 irq no condition");

        // R6 / R7 edge sensing
        wr(8'h20, 32'h0000_0002);
        wr(8'h4C, 32'h0000_0004);
        wr(8'h24, 32'h0000_000F);
        settle();
        rd(8'h10, 0, "R6 no edge yet");
        pin_in = 16'h000F;
        settle();
        rd(8'h10, 32'h0000_000D, "R6 rising edges");
        chk(32'(irq), 1, "R10 irq on edge");
        pin_in = 16'h0000;
        settle();
        rd(8'h10, 32'h0000_000F, "R6 falling edge and latch");
        wr(8'h14, 32'h0000_0005);
        rd(8'h10, 32'h0000_000A, "R8 clear ones");
        wr(8'h14, 32'h0000_0000);
        rd(8'h10, 32'h0000_000A, "R8 zero leaves");
        rd(8'h14, 0, "R12 clear reads zero");
        wr(8'h14, 32'h0000_000F);
        rd(8'h10, 0, "R8 clear all");
        @(negedge clk);
        chk(32'(irq), 0, "R10 irq after clear");
        pin_in = 16'h0004;
        settle();
        rd(8'h10, 32'h0000_0004, "R7 both-edge rise");
        wr(8'h14, 32'h0000_0004);
        rd(8'h10, 0, "R7 cleared");
        pin_in = 16'h0000;
        settle();
        rd(8'h10, 32'h0000_0004, "R7 both-edge fall");
        wr(8'h14, 32'h0000_000F);

        // R8 clear and new edge in the same cycle
        @(negedge clk);
        pin_in = 16'h0001;
        @(negedge clk);
        wr(8'h14, 32'h0000_0001);
        rd(8'h10, 32'h0000_0001, "R8 event beats clear");
        chk(32'(irq), 1, "R10 irq after collision");

        // R12 read data holds
        @(negedge clk);
        @(negedge clk);
        chk(rd_data, 32'h0000_0001, "R12 rd_data holds");

        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule